// File: doc/BRIEF.md
# Receive Descriptor Ring Scatter Engine

This block places one received frame into host memory through a circular ring of 16-byte receive descriptors. A frame arrives as a length on a valid/ready port. Before any memory traffic, the engine works out whether the free descriptors between head and tail can hold the whole frame. If they cannot, it raises a receive-overrun pulse and touches nothing.

If the frame fits, the engine walks the ring from the head. For each descriptor it issues a descriptor fetch, then at most one buffer's worth of payload write, then a descriptor writeback. It advances the head with wraparound after each writeback. When the last descriptor is written back it signals completion.

All memory traffic leaves on a single command port with valid/ready back-pressure:

- The engine raises `cmd_valid` and holds every command field steady until the cycle in which `cmd_ready` is high.
- Descriptor fetch results come back on a separate response strobe carrying the buffer address held in that descriptor.

The frame port also follows valid/ready rules:

- `frm_ready` is a pure function of registered state and configuration.
- A frame is taken on the clock edge where `frm_valid` and `frm_ready` are both high.
- The offered length must stay steady while valid is high.

Top module: `rxring_scatter`

## Requirements
- R1: The ring base is `ring_base_hi` shifted up 32 bits plus `ring_base_lo` with its lowest 4 bits cleared. A descriptor's address is that base plus 16 times the head index.
- R2: `frm_ready` is high only while no frame is in flight, `rx_en` is 1, and either head differs from tail or `ovr_chk_en` is 0. A frame is taken on a clock edge with `frm_valid` and `frm_ready` both high.
- R3: The capacity check works as follows:
  - Frames no larger than `buf_size` are always taken.
  - For larger frames the free descriptor count is chosen by the first rule that applies:
    - head below tail: tail minus head;
    - head above tail, or overrun checking off: ring length/16 plus tail minus head;
    - otherwise: zero.
  - A frame whose total exceeds free descriptors times `buf_size` is dropped. The drop issues no command, leaves head unchanged and gives a one-cycle `irq_rxo` pulse on the cycle after acceptance.
- R4: The frame total is `frm_len` plus 4 when `keep_fcs` is 1, and `frm_len` alone otherwise.
- R5: Each descriptor starts with a fetch command (`cmd_kind` 0) at the descriptor address with `cmd_len` 16. The engine then waits for `rsp_valid` and keeps `rsp_addr` as the buffer address.
- R6: A payload write (`cmd_kind` 1) is issued only when the buffer address is nonzero and the running offset is below `frm_len`. Its fields are:
  - address: the buffer address;
  - `cmd_len`: the smaller of `frm_len` minus offset and `buf_size`;
  - `cmd_offs`: the running offset.
- R7: A writeback (`cmd_kind` 2) goes to the descriptor address for a nonzero buffer.
  - `cmd_len` is the smaller of total minus offset and `buf_size`, and the offset then advances by that amount.
  - Flag bit 0 (done) is always 1.
  - Bits 1 (end of packet) and 2 (checksum ignored) are 1 only when the advanced offset reaches the total. They are 0 otherwise.
- R8: A descriptor with a zero buffer address gets no payload write. Its writeback has `cmd_len` 0 and flags 3'b001. The offset does not advance, but the descriptor is still consumed.
- R9: Head advances by one at each accepted writeback. It becomes 0 instead when (head+1)*16 is at least `ring_len`.
- R10: The accepted writeback that reaches the total is followed on the next cycle by a single-cycle `irq_done` pulse. On that same edge `pkt_good` and `pkt_total` each increase by one.
- R11: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid` and all command fields hold their values into the next cycle.
- R12: With no frame in flight, `head_wr` loads `head_wr_val` into the head on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable |
| ovr_chk_en | input | 1 | Treat head equal to tail as ring full |
| keep_fcs | input | 1 | Count 4 FCS bytes in the frame total |
| ring_base_lo | input | 32 | Ring base, low word |
| ring_base_hi | input | 32 | Ring base, high word |
| ring_len | input | LENW | Ring size in bytes |
| ring_tail | input | IDXW | Tail index from software |
| buf_size | input | BSW | Bytes per descriptor buffer |
| head_wr | input | 1 | Load head strobe |
| head_wr_val | input | IDXW | Value for head load |
| ring_head | output | IDXW | Current head index |
| frm_valid | input | 1 | Frame offered |
| frm_ready | output | 1 | Frame can be taken |
| frm_len | input | FLW | Frame length in bytes |
| cmd_valid | output | 1 | Memory command valid |
| cmd_ready | input | 1 | Memory command accepted |
| cmd_kind | output | 2 | 0 fetch, 1 payload write, 2 writeback |
| cmd_addr | output | 64 | Command address |
| cmd_len | output | BSW | Byte count |
| cmd_offs | output | FLW | Frame offset of payload write |
| cmd_flags | output | 3 | Writeback flags: done, end of packet, checksum ignored |
| rsp_valid | input | 1 | Descriptor fetch result strobe |
| rsp_addr | input | 64 | Buffer address from fetched descriptor |
| irq_rxo | output | 1 | Receive overrun pulse |
| irq_done | output | 1 | Frame complete pulse |
| pkt_good | output | CNTW | Good frame count |
| pkt_total | output | CNTW | Total frame count |

## Verification
The bench first targets the boundaries where an off-by-one shows up:

- **Trailing FCS descriptor.** A frame exactly two buffers long with FCS kept needs a third descriptor that holds only the 4 FCS bytes. A design that wrote payload for it, or flagged end of packet too early, would emit a stray write or lose the final writeback.
- **Null buffer in mid-frame.** A null descriptor must still be written back and consumed. An engine that advanced the offset past it would drop payload, and one that skipped the writeback would leave the head behind.
- **Ring wrap.** Head wraparound is exercised across the ring end.
- **Just-too-large rejection.** A frame slightly larger than the available space must raise overrun without issuing any command.
- **Full ring with the check off.** With head equal to tail and overrun checking off, the whole ring must be usable; a wrong capacity formula would wrongly reject the frame.

Random frames then mix buffer sizes, tails, FCS settings and null slots. They run under a command port whose ready is randomly withheld, so that command fields which change while stalled get caught.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam int DESC_SHIFT = 4;
  localparam int DESC_BYTES = 16;
  localparam int FCS_BYTES  = 4;
  localparam int ADDR_W     = 64;
  localparam int FLAG_W     = 3;
  localparam int FL_DONE    = 0;
  localparam int FL_EOP     = 1;
  localparam int FL_IXSM    = 2;

  typedef enum logic [1:0] {
    CMD_FETCH = 2'd0,
    CMD_WRITE = 2'd1,
    CMD_WBACK = 2'd2
  } cmd_kind_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_WAIT,
    S_WRITE,
    S_WBACK
  } seq_state_e;
endpackage

// File: rtl/rxs_space.sv
module rxs_space
  import rxs_pkg::*;
#(
  parameter int IDXW = 16,
  parameter int LENW = 20,
  parameter int TOTW = 17,
  parameter int BSW  = 16
) (
  input  logic [IDXW-1:0] head,
  input  logic [IDXW-1:0] tail,
  input  logic [LENW-1:0] ring_len,
  input  logic [BSW-1:0]  buf_size,
  input  logic            ovr_chk,
  input  logic [TOTW-1:0] total,
  output logic            any_free,
  output logic            fits
);
  localparam int RDW = LENW - DESC_SHIFT;
  localparam int CW  = ((RDW > IDXW) ? RDW : IDXW) + 2;
  localparam int PW  = CW + BSW + TOTW;

  logic [CW-1:0] ring_desc;
  logic [CW-1:0] head_x;
  logic [CW-1:0] tail_x;
  logic [CW-1:0] bufs;
  logic [PW-1:0] room;
  logic          short_frm;

  always_comb begin
    ring_desc = CW'(ring_len >> DESC_SHIFT);
    head_x    = CW'(head);
    tail_x    = CW'(tail);
    any_free  = (head != tail) || !ovr_chk;
    short_frm = PW'(total) <= PW'(buf_size);
    if (head < tail) begin
      bufs = tail_x - head_x;
    end else if ((head > tail) || !ovr_chk) begin
      bufs = ring_desc + tail_x - head_x;
    end else begin
      bufs = '0;
    end
    room = PW'(bufs) * PW'(buf_size);
    fits = short_frm ? any_free : (PW'(total) <= room);
  end
endmodule

// File: rtl/rxs_ring_ptr.sv
module rxs_ring_ptr
  import rxs_pkg::*;
#(
  parameter int IDXW = 16,
  parameter int LENW = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [IDXW-1:0] load_val,
  input  logic            step,
  input  logic [LENW-1:0] ring_len,
  output logic [IDXW-1:0] head
);
  localparam int EW = ((IDXW + DESC_SHIFT + 1) > LENW) ? (IDXW + DESC_SHIFT + 1) : LENW;

  logic [EW-1:0]   inc_bytes;
  logic [IDXW-1:0] head_inc;

  always_comb begin
    inc_bytes = (EW'(head) + EW'(1)) << DESC_SHIFT;
    head_inc  = (inc_bytes >= EW'(ring_len)) ? '0 : head + IDXW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0;
    end else if (load) begin
      head <= load_val;
    end else if (step) begin
      head <= head_inc;
    end
  end
endmodule

// File: rtl/rxs_seq.sv
module rxs_seq
  import rxs_pkg::*;
#(
  parameter int FLW  = 16,
  parameter int BSW  = 16,
  parameter int CNTW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              any_free,
  input  logic              fits,
  input  logic              frm_valid,
  output logic              frm_ready,
  input  logic [FLW-1:0]    frm_len,
  input  logic [FLW:0]      total,
  input  logic [63:0]       desc_addr,
  input  logic [BSW-1:0]    buf_size,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_kind,
  output logic [63:0]       cmd_addr,
  output logic [BSW-1:0]    cmd_len,
  output logic [FLW-1:0]    cmd_offs,
  output logic [FLAG_W-1:0] cmd_flags,
  input  logic              rsp_valid,
  input  logic [63:0]       rsp_addr,
  output logic              step,
  output logic              idle,
  output logic              irq_rxo,
  output logic              irq_done,
  output logic [CNTW-1:0]   pkt_good,
  output logic [CNTW-1:0]   pkt_total
);
  localparam int TOTW = FLW + 1;
  localparam int DW   = ((TOTW > BSW) ? TOTW : BSW) + 1;

  seq_state_e      state;
  logic [FLW-1:0]  len_q;
  logic [TOTW-1:0] tot_q;
  logic [TOTW-1:0] off_q;
  logic [63:0]     bufa_q;

  logic [DW-1:0] remain_tot;
  logic [DW-1:0] remain_dat;
  logic [DW-1:0] desc_sz;
  logic [DW-1:0] wr_sz;
  logic [DW-1:0] off_next;
  logic          last;
  logic          null_buf;
  logic          has_data;

  always_comb begin
    remain_tot = DW'(tot_q) - DW'(off_q);
    remain_dat = DW'(len_q) - DW'(off_q);
    desc_sz    = (remain_tot > DW'(buf_size)) ? DW'(buf_size) : remain_tot;
    wr_sz      = (remain_dat > DW'(buf_size)) ? DW'(buf_size) : remain_dat;
    off_next   = DW'(off_q) + desc_sz;
    last       = off_next >= DW'(tot_q);
    null_buf   = (bufa_q == '0);
    has_data   = DW'(off_q) < DW'(len_q);
  end

  assign idle      = (state == S_IDLE);
  assign frm_ready = idle && rx_en && any_free;
  assign step      = (state == S_WBACK) && cmd_ready;

  always_comb begin
    cmd_valid = 1'b0;
    cmd_kind  = CMD_FETCH;
    cmd_addr  = desc_addr;
    cmd_len   = '0;
    cmd_offs  = '0;
    cmd_flags = '0;
    case (state)
      S_FETCH: begin
        cmd_valid = 1'b1;
        cmd_len   = BSW'(DESC_BYTES);
      end
      S_WRITE: begin
        cmd_valid = 1'b1;
        cmd_kind  = CMD_WRITE;
        cmd_addr  = bufa_q;
        cmd_len   = BSW'(wr_sz);
        cmd_offs  = FLW'(off_q);
      end
      S_WBACK: begin
        cmd_valid          = 1'b1;
        cmd_kind           = CMD_WBACK;
        cmd_flags[FL_DONE] = 1'b1;
        if (!null_buf) begin
          cmd_len            = BSW'(desc_sz);
          cmd_flags[FL_EOP]  = last;
          cmd_flags[FL_IXSM] = last;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      len_q     <= '0;
      tot_q     <= '0;
      off_q     <= '0;
      bufa_q    <= '0;
      irq_rxo   <= 1'b0;
      irq_done  <= 1'b0;
      pkt_good  <= '0;
      pkt_total <= '0;
    end else begin
      irq_rxo  <= 1'b0;
      irq_done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (frm_valid && frm_ready) begin
            if (fits) begin
              state <= S_FETCH;
              len_q <= frm_len;
              tot_q <= total;
              off_q <= '0;
            end else begin
              irq_rxo <= 1'b1;
            end
          end
        end
        S_FETCH: if (cmd_ready) state <= S_WAIT;
        S_WAIT: begin
          if (rsp_valid) begin
            bufa_q <= rsp_addr;
            state  <= ((rsp_addr != '0) && has_data) ? S_WRITE : S_WBACK;
          end
        end
        S_WRITE: if (cmd_ready) state <= S_WBACK;
        S_WBACK: begin
          if (cmd_ready) begin
            if (!null_buf) off_q <= TOTW'(off_next);
            if (!null_buf && last) begin
              state     <= S_IDLE;
              irq_done  <= 1'b1;
              pkt_good  <= pkt_good + CNTW'(1);
              pkt_total <= pkt_total + CNTW'(1);
            end else begin
              state <= S_FETCH;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rxring_scatter.sv
module rxring_scatter
  import rxs_pkg::*;
#(
  parameter int IDXW = 16,
  parameter int LENW = 20,
  parameter int FLW  = 16,
  parameter int BSW  = 16,
  parameter int CNTW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx_en,
  input  logic            ovr_chk_en,
  input  logic            keep_fcs,
  input  logic [31:0]     ring_base_lo,
  input  logic [31:0]     ring_base_hi,
  input  logic [LENW-1:0] ring_len,
  input  logic [IDXW-1:0] ring_tail,
  input  logic [BSW-1:0]  buf_size,
  input  logic            head_wr,
  input  logic [IDXW-1:0] head_wr_val,
  output logic [IDXW-1:0] ring_head,
  input  logic            frm_valid,
  output logic            frm_ready,
  input  logic [FLW-1:0]  frm_len,
  output logic            cmd_valid,
  input  logic            cmd_ready,
  output logic [1:0]      cmd_kind,
  output logic [63:0]     cmd_addr,
  output logic [BSW-1:0]  cmd_len,
  output logic [FLW-1:0]  cmd_offs,
  output logic [2:0]      cmd_flags,
  input  logic            rsp_valid,
  input  logic [63:0]     rsp_addr,
  output logic            irq_rxo,
  output logic            irq_done,
  output logic [CNTW-1:0] pkt_good,
  output logic [CNTW-1:0] pkt_total
);
  localparam int TOTW = FLW + 1;

  logic [63:0]     ring_base;
  logic [63:0]     desc_addr;
  logic [TOTW-1:0] total;
  logic            any_free;
  logic            fits;
  logic            step;
  logic            idle;

  always_comb begin
    ring_base = {ring_base_hi, 32'h0} + {32'h0, ring_base_lo & ~32'hF};
    desc_addr = ring_base + (64'(ring_head) << DESC_SHIFT);
    total     = TOTW'(frm_len) + (keep_fcs ? TOTW'(FCS_BYTES) : TOTW'(0));
  end

  rxs_space #(.IDXW(IDXW), .LENW(LENW), .TOTW(TOTW), .BSW(BSW)) u_space (
    .head     (ring_head),
    .tail     (ring_tail),
    .ring_len (ring_len),
    .buf_size (buf_size),
    .ovr_chk  (ovr_chk_en),
    .total    (total),
    .any_free (any_free),
    .fits     (fits)
  );

  rxs_ring_ptr #(.IDXW(IDXW), .LENW(LENW)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (head_wr && idle),
    .load_val (head_wr_val),
    .step     (step),
    .ring_len (ring_len),
    .head     (ring_head)
  );

  rxs_seq #(.FLW(FLW), .BSW(BSW), .CNTW(CNTW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_en     (rx_en),
    .any_free  (any_free),
    .fits      (fits),
    .frm_valid (frm_valid),
    .frm_ready (frm_ready),
    .frm_len   (frm_len),
    .total     (total),
    .desc_addr (desc_addr),
    .buf_size  (buf_size),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_kind  (cmd_kind),
    .cmd_addr  (cmd_addr),
    .cmd_len   (cmd_len),
    .cmd_offs  (cmd_offs),
    .cmd_flags (cmd_flags),
    .rsp_valid (rsp_valid),
    .rsp_addr  (rsp_addr),
    .step      (step),
    .idle      (idle),
    .irq_rxo   (irq_rxo),
    .irq_done  (irq_done),
    .pkt_good  (pkt_good),
    .pkt_total (pkt_total)
  );
endmodule

// File: rtl/rxring_scatter_chk.sv
module rxring_scatter_chk #(
  parameter int IDXW = 16,
  parameter int FLW  = 16,
  parameter int BSW  = 16,
  parameter int CNTW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rx_en,
  input logic            head_wr,
  input logic [IDXW-1:0] ring_head,
  input logic            frm_ready,
  input logic            cmd_valid,
  input logic            cmd_ready,
  input logic [1:0]      cmd_kind,
  input logic [63:0]     cmd_addr,
  input logic [BSW-1:0]  cmd_len,
  input logic [FLW-1:0]  cmd_offs,
  input logic [2:0]      cmd_flags,
  input logic            irq_rxo,
  input logic            irq_done,
  input logic [CNTW-1:0] pkt_total
);
  p_cmd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_kind) && $stable(cmd_addr)
      && $stable(cmd_len) && $stable(cmd_offs) && $stable(cmd_flags));

  p_ready_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frm_ready |-> rx_en && !cmd_valid);

  p_reject_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rxo |-> !cmd_valid && $stable(ring_head));

  p_wback_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_kind == 2'd2) |-> cmd_flags[0] && (cmd_flags[1] == cmd_flags[2]));

  p_head_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(head_wr) && (ring_head != $past(ring_head))
      |-> (ring_head == '0) || (ring_head == IDXW'($past(ring_head) + 1'b1)));

  p_done_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |-> pkt_total == CNTW'($past(pkt_total) + 1'b1));

  p_pulse_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_done && irq_rxo));
endmodule

bind rxring_scatter rxring_scatter_chk #(.IDXW(IDXW), .FLW(FLW), .BSW(BSW), .CNTW(CNTW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_en     (rx_en),
  .head_wr   (head_wr),
  .ring_head (ring_head),
  .frm_ready (frm_ready),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_kind  (cmd_kind),
  .cmd_addr  (cmd_addr),
  .cmd_len   (cmd_len),
  .cmd_offs  (cmd_offs),
  .cmd_flags (cmd_flags),
  .irq_rxo   (irq_rxo),
  .irq_done  (irq_done),
  .pkt_total (pkt_total)
);

// File: tb/rxring_scatter_test.sv
module rxring_scatter_test;
  localparam int IDXW = 16, LENW = 20, FLW = 16, BSW = 16, CNTW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_en = 1'b0, ovr_chk_en = 1'b1, keep_fcs = 1'b0;
  logic [31:0] ring_base_lo = '0, ring_base_hi = '0;
  logic [LENW-1:0] ring_len = '0;
  logic [IDXW-1:0] ring_tail = '0;
  logic [BSW-1:0] buf_size = '0;
  logic head_wr = 1'b0;
  logic [IDXW-1:0] head_wr_val = '0;
  logic [IDXW-1:0] ring_head;
  logic frm_valid = 1'b0;
  logic frm_ready;
  logic [FLW-1:0] frm_len = '0;
  logic cmd_valid;
  logic cmd_ready = 1'b0;
  logic [1:0] cmd_kind;
  logic [63:0] cmd_addr;
  logic [BSW-1:0] cmd_len;
  logic [FLW-1:0] cmd_offs;
  logic [2:0] cmd_flags;
  logic rsp_valid = 1'b0;
  logic [63:0] rsp_addr = '0;
  logic irq_rxo, irq_done;
  logic [CNTW-1:0] pkt_good, pkt_total;

  always #4 clk = ~clk;

  rxring_scatter #(.IDXW(IDXW), .LENW(LENW), .FLW(FLW), .BSW(BSW), .CNTW(CNTW)) uut (.*);

  typedef struct {
    int          kind;
    logic [63:0] addr;
    int          len;
    int          offs;
    int          flags;
  } exp_t;

  exp_t expq[$];
  int checks = 0, errors = 0;
  int done_cnt = 0, rxo_cnt = 0, good_exp = 0;
  int mh = 0, tail = 0, rlen = 128, bs = 64;
  bit ovr = 1, fcs = 0;
  logic [63:0] base = '0;
  logic [63:0] bufmem [8];
  bit finished = 0;

  task automatic chk(string req, string what, longint act, longint expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic int nxt(int h);
    return ((h + 1) * 16 >= rlen) ? 0 : h + 1;
  endfunction

  function automatic void push(int k, logic [63:0] a, int l, int o, int f);
    exp_t e;
    e.kind = k; e.addr = a; e.len = l; e.offs = o; e.flags = f;
    expq.push_back(e);
  endfunction

  function automatic bit avail_now();
    return (mh != tail) || !ovr;
  endfunction

  function automatic bit plan_frame(int len);
    int total, bufs, off, ds, wl;
    bit ok;
    logic [63:0] da, ba;
    total = len + (fcs ? 4 : 0);
    if (total <= bs) ok = avail_now();
    else begin
      if (mh < tail) bufs = tail - mh;
      else if (mh > tail || !ovr) bufs = rlen / 16 + tail - mh;
      else bufs = 0;
      ok = total <= bufs * bs;
    end
    if (!ok) return 0;
    off = 0;
    while (off < total) begin
      da = base + 64'(mh * 16);
      push(0, da, 16, 0, 0);
      ba = bufmem[mh];
      if (ba != 0) begin
        ds = total - off; if (ds > bs) ds = bs;
        if (off < len) begin
          wl = len - off; if (wl > bs) wl = bs;
          push(1, ba, wl, off, 0);
        end
        off += ds;
        push(2, da, ds, 0, (off >= total) ? 7 : 1);
      end else begin
        push(2, da, 0, 0, 1);
      end
      mh = nxt(mh);
    end
    return 1;
  endfunction

  // DMA responder and command monitor
  initial begin
    int rsp_wait;
    logic [63:0] pend;
    bit pv, pa;
    logic [1:0] pk; logic [63:0] pad; logic [BSW-1:0] pl; logic [FLW-1:0] po; logic [2:0] pf;
    rsp_wait = 0; pend = '0; pv = 0; pa = 0;
    pk = '0; pad = '0; pl = '0; po = '0; pf = '0;
    forever begin
      @(negedge clk);
      if (irq_done) done_cnt++;
      if (irq_rxo) rxo_cnt++;
      if (rsp_valid) rsp_valid = 1'b0;
      if (rsp_wait > 0) begin
        rsp_wait--;
        if (rsp_wait == 0) begin rsp_valid = 1'b1; rsp_addr = pend; end
      end
      if (pv && !pa) begin
        // R11: a stalled command keeps its fields
        chk("R11", "valid held", longint'(cmd_valid), 1);
        chk("R11", "fields held", longint'({cmd_kind, cmd_len, cmd_offs, cmd_flags} == {pk, pl, po, pf} && cmd_addr == pad), 1);
      end
      cmd_ready = ($urandom % 4) != 0;
      pv = cmd_valid; pa = cmd_valid && cmd_ready;
      pk = cmd_kind; pad = cmd_addr; pl = cmd_len; po = cmd_offs; pf = cmd_flags;
      if (cmd_valid && cmd_ready) begin
        if (expq.size() == 0) begin
          chk("R3", "unexpected command", 1, 0);
        end else begin
          exp_t e;
          string rq;
          e = expq.pop_front();
          rq = (e.kind == 0) ? "R1 R5" : (e.kind == 1) ? "R6" : (e.len == 0) ? "R8" : "R7";
          chk(rq, "kind", longint'(cmd_kind), e.kind);
          chk(rq, "addr", longint'(cmd_addr), longint'(e.addr));
          chk(rq, "len", longint'(cmd_len), e.len);
          if (e.kind == 1) chk(rq, "offs", longint'(cmd_offs), e.offs);
          if (e.kind == 2) chk(rq, "flags", longint'(cmd_flags), e.flags);
        end
        if (cmd_kind == 2'd0) begin
          rsp_wait = 1 + ($urandom % 3);
          pend = bufmem[((cmd_addr - base) >> 4) & 64'h7];
        end
      end
    end
  end

  task automatic apply_cfg();
    @(negedge clk);
    ovr_chk_en = ovr; keep_fcs = fcs; ring_tail = IDXW'(tail);
    ring_len = LENW'(rlen); buf_size = BSW'(bs);
  endtask

  task automatic set_head(int h);
    @(negedge clk); head_wr = 1'b1; head_wr_val = IDXW'(h);
    @(negedge clk); head_wr = 1'b0; mh = h;
    chk("R12", "head load", longint'(ring_head), h);
  endtask

  task automatic send(int len, string tag);
    bit ok;
    int d0, r0;
    @(negedge clk);
    chk("R2", {tag, " ready"}, longint'(frm_ready), 1);
    if (!frm_ready) return;
    ok = plan_frame(len);
    d0 = done_cnt; r0 = rxo_cnt;
    frm_len = FLW'(len); frm_valid = 1'b1;
    @(negedge clk); frm_valid = 1'b0;
    for (int i = 0; i < 3000 && done_cnt == d0 && rxo_cnt == r0; i++) @(negedge clk);
    if (ok) begin
      good_exp++;
      chk("R10", {tag, " done pulse"}, done_cnt - d0, 1);
      chk("R10", {tag, " good count"}, longint'(pkt_good), good_exp);
      chk("R10", {tag, " total count"}, longint'(pkt_total), good_exp);
    end else begin
      chk("R3", {tag, " overrun pulse"}, rxo_cnt - r0, 1);
      chk("R3", {tag, " no done"}, done_cnt - d0, 0);
    end
    chk("R5", {tag, " all commands seen"}, expq.size(), 0);
    expq.delete();
    chk("R9", {tag, " head"}, longint'(ring_head), mh);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) bufmem[i] = 64'h0000_0004_0000_0000 + 64'(i) * 64'h1000;
    ring_base_hi = 32'h1; ring_base_lo = 32'h2000_0009;
    base = 64'h1_2000_0000;
    tail = 7; apply_cfg();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", "reset head", longint'(ring_head), 0);
    chk("R11", "reset cmd_valid", longint'(cmd_valid), 0);
    chk("R10", "reset counters", longint'(pkt_good) + longint'(pkt_total), 0);
    chk("R2", "ready low while disabled", longint'(frm_ready), 0);
    frm_valid = 1'b1; frm_len = 16'd40;
    repeat (5) @(negedge clk);
    frm_valid = 1'b0;
    chk("R2", "disabled frame ignored", done_cnt + rxo_cnt, 0);
    rx_en = 1'b1;

    send(40, "single");
    // R4: two full buffers plus FCS needs a third, write-free descriptor
    fcs = 1; bs = 64; apply_cfg();
    send(128, "fcs-tail");
    fcs = 0; apply_cfg();
    // R8: null buffer in mid-frame
    set_head(0); tail = 7; apply_cfg();
    bufmem[1] = '0;
    send(100, "null");
    bufmem[1] = 64'h0000_0004_0000_1000;
    // R9: wrap across ring end
    set_head(6); tail = 3; apply_cfg();
    send(180, "wrap");
    // R3: just too large
    set_head(2); tail = 3; apply_cfg();
    send(65, "reject");
    // R2: full ring with check on / off
    set_head(4); tail = 4; apply_cfg();
    @(negedge clk);
    chk("R2", "head==tail blocks", longint'(frm_ready), 0);
    ovr = 0; apply_cfg();
    send(500, "full ring");
    ovr = 1;

    for (int n = 0; n < 60; n++) begin
      int pick;
      pick = $urandom % 3;
      bs = (pick == 0) ? 64 : (pick == 1) ? 128 : 256;
      rlen = (($urandom % 2) == 0) ? 128 : 64;
      fcs = ($urandom % 2) == 1;
      ovr = ($urandom % 5) != 0;
      tail = $urandom % (rlen / 16);
      for (int i = 0; i < 8; i++) bufmem[i] = 64'h0000_0008_0000_0000 + 64'($urandom % 4096) * 64'h40 + 64'h40;
      if (($urandom % 5) == 0) bufmem[$urandom % (rlen / 16)] = '0;
      if (mh >= rlen / 16) set_head(0);
      apply_cfg();
      if (avail_now()) send(1 + ($urandom % 600), "random");
      else begin
        @(negedge clk);
        chk("R2", "random blocked", longint'(frm_ready), 0);
      end
    end

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule